// File: doc/BRIEF.md
# Physical Access Target Decoder

This block classifies every physical access that a core issues (instruction fetch, data load, store or atomic read-modify-write) before it leaves the core. From the address, the access size and the access kind it decides, within the same cycle, which of four targets owns the access. The targets are the RAM segment, the ROM segment, the timer/interrupt device window and the host-interface mailbox port. The result is a one-hot target select. Accesses that no target claims produce an access fault, and the fault's class depends on the access kind.

All region bases and sizes are elaboration parameters. Bounds are compared on a widened datapath, so a region that reaches the last byte of the address space still matches. An access that would run past that byte is refused. RAM and ROM together form physical memory, and a separate flag reports a hit in either one. The decoder has no state. The core registers its outputs wherever its pipeline needs them.

Top module: `mmio_addr_decoder`

## Requirements
- R1: An access of 2^size_i bytes hits a window [B, B+S) only when B <= addr_i and addr_i + 2^size_i <= B + S. One byte too far at either end is a miss.
- R2: The end-of-window comparison does not wrap. With RAM at 0x8000_0000 of size 0x8000_0000, an 8-byte access at 0xFFFF_FFF8 and a 1-byte access at 0xFFFF_FFFF select RAM, while an 8-byte access at 0xFFFF_FFFC is a miss.
- R3: tgt_sel_o has bit 0 for RAM, bit 1 for ROM, bit 2 for the timer device and bit 3 for the host port. mem_hit_o is 1 exactly when RAM or ROM is selected.
- R4: Addresses inside the timer window select bit 2 for any legal size that fits inside the window.
- R5: The host port is selected only at HOST_BASE (sizes of 1, 2, 4 or 8 bytes), or at HOST_BASE+4 when the size is exactly 4 bytes (size_i = 2). Any other address or size near it is a miss.
- R6: The targets are decoded in a fixed order: RAM first, then ROM, then the timer device, then the host port. When the timer window and the host port overlap, the timer device wins.
- R7: On a miss, fault_o is 1 and fault_code_o gives the class of the fault. kind_i 0 (fetch) gives code 1 (instruction access), kind_i 1 (load) gives code 2 (load access), and kind_i 2 (store) or 3 (atomic) gives code 3 (store/atomic access). On a hit, fault_code_o is 0.
- R8: size_i is the log2 of the byte count. Values 4 to 7 (more than 8 bytes) are misses at every address, including addresses inside mapped windows.
- R9: tgt_sel_o has at most one bit set, and fault_o is 1 exactly when tgt_sel_o is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | AW | Physical byte address of the access |
| size_i | input | 3 | log2 of the access size in bytes |
| kind_i | input | 2 | 0 fetch, 1 load, 2 store, 3 atomic |
| tgt_sel_o | output | 4 | One-hot target: bit0 RAM, bit1 ROM, bit2 timer, bit3 host port |
| mem_hit_o | output | 1 | Access lands in RAM or ROM |
| fault_o | output | 1 | No target claims the access |
| fault_code_o | output | 2 | 0 none, 1 instruction access, 2 load access, 3 store/atomic access |

## Verification
The timer window and the host port can both claim the same address when their parameters overlap. In that case the decoder must resolve the claim in one evaluation. A second instance in the bench places the host port inside the timer window, at both the port base and base+4. Each check expects only the timer bit set with no fault. Range overflow and the fault classes are also checked near the top of the address space, where an overflowing adder would pick the wrong target.

// File: rtl/mmio_dec_pkg.sv
package mmio_dec_pkg;

    localparam int unsigned NTGT     = 4;
    localparam int unsigned SIZE_W   = 3;
    localparam int unsigned MAX_LOG2 = 3;

    localparam int unsigned TGT_RAM   = 0;
    localparam int unsigned TGT_ROM   = 1;
    localparam int unsigned TGT_TIMER = 2;
    localparam int unsigned TGT_HOST  = 3;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'd0,
        KIND_LOAD  = 2'd1,
        KIND_STORE = 2'd2,
        KIND_AMO   = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_INSTR = 2'd1,
        FLT_LOAD  = 2'd2,
        FLT_STAMO = 2'd3
    } flt_code_e;

    typedef struct packed {
        logic [NTGT-1:0] sel;
        logic            mem;
        logic            fault;
        logic [1:0]      code;
    } dec_t;

endpackage

// File: rtl/mmio_window_match.sv
module mmio_window_match #(
    parameter int unsigned AW   = 32,
    parameter logic [AW:0] BASE = '0,
    parameter logic [AW:0] SIZE = '0
) (
    input  logic [AW-1:0] addr_i,
    input  logic [AW:0]   nbytes_i,
    output logic          hit_o
);
    localparam int unsigned EW = AW + 2;
    localparam logic [EW-1:0] LO_X  = {1'b0, BASE};
    localparam logic [EW-1:0] END_X = {1'b0, BASE} + {1'b0, SIZE};

    logic [EW-1:0] start_x;
    logic [EW-1:0] stop_x;

    always_comb begin
        start_x = {2'b00, addr_i};
        stop_x  = start_x + {1'b0, nbytes_i};
        hit_o   = (start_x >= LO_X) && (stop_x <= END_X);
    end
endmodule

// File: rtl/mmio_host_match.sv
module mmio_host_match #(
    parameter int unsigned AW        = 32,
    parameter logic [AW-1:0] HOST_BASE = '0
) (
    input  logic [AW-1:0] addr_i,
    input  logic [2:0]    size_i,
    input  logic          size_ok_i,
    output logic          hit_o
);
    localparam logic [AW:0] LO_X = {1'b0, HOST_BASE};
    localparam logic [AW:0] HI_X = {1'b0, HOST_BASE} + (AW+1)'(4);

    logic at_lo;
    logic at_hi;

    always_comb begin
        at_lo = ({1'b0, addr_i} == LO_X);
        at_hi = ({1'b0, addr_i} == HI_X) && (size_i == 3'd2);
        hit_o = size_ok_i && (at_lo || at_hi);
    end
endmodule

// File: rtl/mmio_fault_class.sv
module mmio_fault_class
    import mmio_dec_pkg::*;
(
    input  logic [1:0] kind_i,
    input  logic       miss_i,
    output logic [1:0] code_o
);
    always_comb begin
        code_o = FLT_NONE;
        if (miss_i) begin
            unique case (acc_kind_e'(kind_i))
                KIND_FETCH: code_o = FLT_INSTR;
                KIND_LOAD:  code_o = FLT_LOAD;
                default:    code_o = FLT_STAMO;
            endcase
        end
    end
endmodule

// File: rtl/mmio_addr_decoder.sv
module mmio_addr_decoder
    import mmio_dec_pkg::*;
#(
    parameter int unsigned   AW         = 32,
    parameter logic [AW-1:0] RAM_BASE   = 32'h8000_0000,
    parameter logic [AW:0]   RAM_SIZE   = 33'h0_8000_0000,
    parameter logic [AW-1:0] ROM_BASE   = 32'h0000_1000,
    parameter logic [AW:0]   ROM_SIZE   = 33'h0_0000_1000,
    parameter logic [AW-1:0] TIMER_BASE = 32'h0200_0000,
    parameter logic [AW:0]   TIMER_SIZE = 33'h0_0000_C000,
    parameter logic [AW-1:0] HOST_BASE  = 32'h4000_0000
) (
    input  logic [AW-1:0] addr_i,
    input  logic [2:0]    size_i,
    input  logic [1:0]    kind_i,
    output logic [3:0]    tgt_sel_o,
    output logic          mem_hit_o,
    output logic          fault_o,
    output logic [1:0]    fault_code_o
);
    localparam int unsigned NWIN = 3;
    localparam logic [AW:0] WIN_BASE [NWIN] = '{
        {1'b0, RAM_BASE}, {1'b0, ROM_BASE}, {1'b0, TIMER_BASE}
    };
    localparam logic [AW:0] WIN_SIZE [NWIN] = '{RAM_SIZE, ROM_SIZE, TIMER_SIZE};

    logic            size_ok;
    logic [AW:0]     nbytes;
    logic [NWIN-1:0] win_hit;
    logic            host_hit;
    logic [1:0]      code;
    dec_t            dec_d;

    always_comb begin
        size_ok = (size_i <= SIZE_W'(MAX_LOG2));
        nbytes  = (AW+1)'(1) << size_i[1:0];
    end

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        logic raw_hit;
        mmio_window_match #(
            .AW   (AW),
            .BASE (WIN_BASE[g]),
            .SIZE (WIN_SIZE[g])
        ) u_match (
            .addr_i   (addr_i),
            .nbytes_i (nbytes),
            .hit_o    (raw_hit)
        );
        assign win_hit[g] = raw_hit && size_ok;
    end

    mmio_host_match #(
        .AW        (AW),
        .HOST_BASE (HOST_BASE)
    ) u_host (
        .addr_i    (addr_i),
        .size_i    (size_i),
        .size_ok_i (size_ok),
        .hit_o     (host_hit)
    );

    // Ordered claim: RAM, ROM, timer, host port.
    always_comb begin
        dec_d = '0;
        if (win_hit[0])      dec_d.sel[TGT_RAM]   = 1'b1;
        else if (win_hit[1]) dec_d.sel[TGT_ROM]   = 1'b1;
        else if (win_hit[2]) dec_d.sel[TGT_TIMER] = 1'b1;
        else if (host_hit)   dec_d.sel[TGT_HOST]  = 1'b1;
        dec_d.mem   = win_hit[0] || win_hit[1];
        dec_d.fault = !(|win_hit) && !host_hit;
        dec_d.code  = code;
    end

    mmio_fault_class u_class (
        .kind_i (kind_i),
        .miss_i (dec_d.fault),
        .code_o (code)
    );

    assign tgt_sel_o    = dec_d.sel;
    assign mem_hit_o    = dec_d.mem;
    assign fault_o      = dec_d.fault;
    assign fault_code_o = dec_d.code;
endmodule

// File: rtl/mmio_addr_decoder_chk.sv
module mmio_addr_decoder_chk #(
    parameter int unsigned   AW        = 32,
    parameter logic [AW-1:0] HOST_BASE = '0
) (
    input logic [AW-1:0] addr_i,
    input logic [2:0]    size_i,
    input logic [1:0]    kind_i,
    input logic [3:0]    tgt_sel_o,
    input logic          mem_hit_o,
    input logic          fault_o,
    input logic [1:0]    fault_code_o
);
    always_comb begin
        if (!$isunknown({addr_i, size_i, kind_i})) begin
            a_r9_onehot: assert ($onehot0(tgt_sel_o));
            a_r9_fault_iff_none: assert (fault_o == (tgt_sel_o == 4'b0000));
            a_r8_wide_misses: assert (!(size_i > 3'd3) || fault_o);
            a_r7_code_zero_on_hit: assert (fault_o || fault_code_o == 2'd0);
            a_r7_fetch_class: assert (!(fault_o && kind_i == 2'd0) || fault_code_o == 2'd1);
            a_r7_load_class: assert (!(fault_o && kind_i == 2'd1) || fault_code_o == 2'd2);
            a_r7_write_class: assert (!(fault_o && kind_i[1]) || fault_code_o == 2'd3);
            a_r3_mem_flag: assert (mem_hit_o == (tgt_sel_o[0] || tgt_sel_o[1]));
            a_r5_host_upper_word: assert (!tgt_sel_o[3] || addr_i == HOST_BASE || size_i == 3'd2);
        end
    end
endmodule

bind mmio_addr_decoder mmio_addr_decoder_chk #(
    .AW        (AW),
    .HOST_BASE (HOST_BASE)
) u_chk (
    .addr_i       (addr_i),
    .size_i       (size_i),
    .kind_i       (kind_i),
    .tgt_sel_o    (tgt_sel_o),
    .mem_hit_o    (mem_hit_o),
    .fault_o      (fault_o),
    .fault_code_o (fault_code_o)
);

// File: tb/mmio_addr_decoder_test.sv
module mmio_addr_decoder_test;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [31:0] addr;
    logic [2:0]  size;
    logic [1:0]  kind;
    logic [3:0]  sel;
    logic        mem;
    logic        flt;
    logic [1:0]  code;
    logic [3:0]  p_sel;
    logic        p_mem;
    logic        p_flt;
    logic [1:0]  p_code;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    mmio_addr_decoder uut (
        .addr_i(addr), .size_i(size), .kind_i(kind),
        .tgt_sel_o(sel), .mem_hit_o(mem), .fault_o(flt), .fault_code_o(code)
    );

    // Host port placed inside the timer window to provoke a double claim.
    mmio_addr_decoder #(.HOST_BASE(32'h0200_4000)) prio (
        .addr_i(addr), .size_i(size), .kind_i(kind),
        .tgt_sel_o(p_sel), .mem_hit_o(p_mem), .fault_o(p_flt), .fault_code_o(p_code)
    );

    localparam logic [3:0] S_RAM = 4'b0001, S_ROM = 4'b0010,
                           S_TMR = 4'b0100, S_HST = 4'b1000, S_NONE = 4'b0000;

    task automatic probe(input string req, input logic [31:0] a, input logic [2:0] s,
                         input logic [1:0] k, input logic [3:0] e_sel, input logic [1:0] e_code,
                         input bit use_prio);
        logic [7:0] got, exp;
        @(negedge clk);
        addr = a; size = s; kind = k;
        @(posedge clk);
        #1;
        exp = {e_sel, (e_sel[0] | e_sel[1]), (e_sel == 4'b0), e_code};
        got = use_prio ? {p_sel, p_mem, p_flt, p_code} : {sel, mem, flt, code};
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h size=%0d kind=%0d got sel/mem/flt/code=%b expected %b",
                     req, a, s, k, got, exp);
        end
    endtask

    task automatic t_idle();
        probe("R7", 32'h0, 3'd0, 2'd0, S_NONE, 2'd1, 0);
    endtask

    task automatic t_bounds();
        probe("R1", 32'h8000_0000, 3'd3, 2'd1, S_RAM, 2'd0, 0);
        probe("R1", 32'h7FFF_FFFF, 3'd0, 2'd1, S_NONE, 2'd2, 0);
        probe("R3", 32'h0000_1000, 3'd0, 2'd0, S_ROM, 2'd0, 0);
        probe("R3", 32'h0000_1FF8, 3'd3, 2'd1, S_ROM, 2'd0, 0);
        probe("R1", 32'h0000_1FFC, 3'd3, 2'd1, S_NONE, 2'd2, 0);
        probe("R1", 32'h0000_0FFF, 3'd0, 2'd0, S_NONE, 2'd1, 0);
    endtask

    task automatic t_top_of_space();
        probe("R2", 32'hFFFF_FFF8, 3'd3, 2'd2, S_RAM, 2'd0, 0);
        probe("R2", 32'hFFFF_FFFF, 3'd0, 2'd1, S_RAM, 2'd0, 0);
        probe("R2", 32'hFFFF_FFFC, 3'd3, 2'd2, S_NONE, 2'd3, 0);
        probe("R2", 32'hFFFF_FFFE, 3'd2, 2'd0, S_NONE, 2'd1, 0);
    endtask

    task automatic t_timer();
        probe("R4", 32'h0200_0000, 3'd2, 2'd1, S_TMR, 2'd0, 0);
        probe("R4", 32'h0200_BFF8, 3'd3, 2'd2, S_TMR, 2'd0, 0);
        probe("R4", 32'h0200_BFFC, 3'd3, 2'd3, S_NONE, 2'd3, 0);
    endtask

    task automatic t_host();
        probe("R5", 32'h4000_0000, 3'd3, 2'd2, S_HST, 2'd0, 0);
        probe("R5", 32'h4000_0000, 3'd0, 2'd1, S_HST, 2'd0, 0);
        probe("R5", 32'h4000_0004, 3'd2, 2'd2, S_HST, 2'd0, 0);
        probe("R5", 32'h4000_0004, 3'd3, 2'd2, S_NONE, 2'd3, 0);
        probe("R5", 32'h4000_0004, 3'd1, 2'd1, S_NONE, 2'd2, 0);
        probe("R5", 32'h4000_0008, 3'd2, 2'd3, S_NONE, 2'd3, 0);
        probe("R5", 32'h4000_0002, 3'd1, 2'd0, S_NONE, 2'd1, 0);
    endtask

    task automatic t_wide();
        probe("R8", 32'h8000_0000, 3'd4, 2'd1, S_NONE, 2'd2, 0);
        probe("R8", 32'h0000_1000, 3'd7, 2'd0, S_NONE, 2'd1, 0);
        probe("R8", 32'h4000_0000, 3'd5, 2'd3, S_NONE, 2'd3, 0);
    endtask

    task automatic t_priority();
        probe("R6", 32'h0200_4000, 3'd3, 2'd2, S_TMR, 2'd0, 1);
        probe("R6", 32'h0200_4004, 3'd2, 2'd1, S_TMR, 2'd0, 1);
        probe("R9", 32'h0300_0000, 3'd2, 2'd2, S_NONE, 2'd3, 1);
    endtask

    initial begin
        addr = '0; size = '0; kind = '0;
        t_idle();
        t_bounds();
        t_top_of_space();
        t_timer();
        t_host();
        t_wide();
        t_priority();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule